// File: doc/BRIEF.md
# Interrupt Pending State Tracker

This block keeps a small state record for each interrupt source. The four states are inactive, pending, active, and active-and-pending. A dispatcher uses it to decide which request to service next. Peripheral request lines come in through one register stage. A per-source mode bit then treats each line either as a level request or as a pulse request. Software can mark a source pending or clear it with strobe vectors, and it can also raise one source by its index.

A simple processor model sends two handshakes, each carrying a source index: handler entry and handler return. On entry, a pending source becomes active. On return, a level source re-samples its line and may become pending again at once. A pulse source stays pending only if a new pulse was latched while its handler ran. The block outputs the pending and active vectors and the lowest-numbered source that is pending but not active, with a valid flag.

Top module: `irq_state_tracker`

## Requirements
- R1: After reset every source is inactive: the pending vector, the active vector and the valid flag are all 0.
- R2: A level source (mode bit 0) whose request line is high while the source is not active becomes pending. This shows on the pending output two clock edges after the line rises, because the line is registered once first.
- R3: A pulse source (mode bit 1) becomes pending on a rising edge of its registered line. A line held high gives only one edge event, so once cleared the source stays clear while the line stays high.
- R4: Bit i of the software set strobe makes source i pending on the next edge. A trigger strobe with index j does the same for source j. A trigger index at or above the source count changes nothing.
- R5: A pending source stays pending until its handler is entered or bit i of the software clear strobe is given. The clear takes effect on the next edge.
- R6: When a set strobe and a clear strobe hit the same source in the same cycle, the source ends up pending. A live hardware request (a level line high on an inactive source) also overrides a clear.
- R7: Handler entry with index i makes a pending, non-active source active and drops its pending flag. The exception is a level source whose line is still high, which becomes active-and-pending. Entry on a source that is not pending, or is already active, is ignored.
- R8: On handler return for an active level source, the source becomes inactive, and its pending flag becomes the current registered line value. A high line leaves it pending; a low line leaves it inactive.
- R9: On handler return for an active pulse source, the source becomes inactive. It is still pending afterwards if a pulse or set arrived during the handler; otherwise it is fully inactive.
- R10: The valid flag is high exactly when some source is pending and not active. When it is high, the index output names the lowest-numbered such source. The index output is combinational from registered state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| req_i | input | NUM_SRC | Peripheral request lines |
| mode_pulse_i | input | NUM_SRC | Per-source mode: 1 pulse, 0 level |
| sw_set_i | input | NUM_SRC | Software set-pending strobes |
| sw_clr_i | input | NUM_SRC | Software clear-pending strobes |
| trig_vld_i | input | 1 | Software trigger strobe |
| trig_idx_i | input | TRIG_W | Source index named by the trigger |
| enter_vld_i | input | 1 | Handler entry handshake |
| enter_idx_i | input | IDX_W | Source whose handler is entered |
| ret_vld_i | input | 1 | Handler return handshake |
| ret_idx_i | input | IDX_W | Source whose handler returns |
| pend_o | output | NUM_SRC | Pending flag per source |
| act_o | output | NUM_SRC | Active flag per source |
| top_vld_o | output | 1 | A dispatchable source exists |
| top_idx_o | output | IDX_W | Lowest-numbered pending, non-active source |

## Verification
A wrong pending or active bit appears directly on pend_o or act_o one edge after the strobe or handshake that caused it. A corrupted request sample appears two edges after the line moves. A stale edge register would show up as a second pending event on a held pulse line after a clear, visible a cycle later. A bad pick shows on top_idx_o in the same cycle as the registered state that feeds it. Because of this, every check samples a fixed number of edges after its stimulus, with no long waits.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;

    typedef struct packed {
        logic pend;
        logic act;
    } src_state_t;

    typedef struct packed {
        logic line;
        logic prev;
    } samp_state_t;

endpackage

// File: rtl/irq_req_sampler.sv
module irq_req_sampler
    import irq_trk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic line_o,
    output logic rise_o
);

    samp_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.line = req_i;
        st_d.prev = st_q.line;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_o = st_q.line;
    assign rise_o = st_q.line & ~st_q.prev;

    AST_ONE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o) else $error("rise held"); // R3

endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_trk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic rise_i,
    input  logic pulse_mode_i,
    input  logic sw_set_i,
    input  logic sw_clr_i,
    input  logic trig_hit_i,
    input  logic enter_hit_i,
    input  logic ret_hit_i,
    output logic pend_o,
    output logic act_o
);

    src_state_t st_d, st_q;
    logic hw_req;
    logic set_any;
    logic enter_ok;
    logic ret_ok;

    always_comb begin
        st_d     = st_q;
        hw_req   = pulse_mode_i ? rise_i : ((line_i & ~st_q.act) | rise_i);
        set_any  = sw_set_i | trig_hit_i | hw_req;
        enter_ok = enter_hit_i & st_q.pend & ~st_q.act;
        ret_ok   = ret_hit_i & st_q.act;
        if (ret_ok) begin
            st_d.act  = 1'b0;
            st_d.pend = pulse_mode_i ? (st_q.pend | set_any) : (set_any | line_i);
        end else if (enter_ok) begin
            st_d.act  = 1'b1;
            st_d.pend = set_any;
        end else begin
            st_d.pend = set_any | (st_q.pend & ~sw_clr_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign act_o  = st_q.act;

    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        sw_set_i |=> pend_o) else $error("set lost"); // R6
    AST_ENTER_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_hit_i && pend_o && !act_o && !ret_hit_i) |=> act_o) else $error("entry lost"); // R7
    AST_RET_DEACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_hit_i && act_o) |=> !act_o) else $error("return lost"); // R8
    AST_LEVEL_RET_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_hit_i && act_o && !pulse_mode_i && line_i) |=> pend_o) else $error("level resample"); // R8
    AST_PULSE_RET_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_hit_i && act_o && pulse_mode_i && pend_o) |=> pend_o) else $error("pulse latch lost"); // R9
    AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_o && !pend_o) |=> !act_o) else $error("activated without pending"); // R7

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] cand_i,
    output logic               vld_o,
    output logic [IDX_W-1:0]   idx_o
);

    always_comb begin
        vld_o = 1'b0;
        idx_o = '0;
        for (int k = NUM_SRC - 1; k >= 0; k--) begin
            if (cand_i[k]) begin
                vld_o = 1'b1;
                idx_o = IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/irq_state_tracker.sv
module irq_state_tracker #(
    parameter int NUM_SRC = 8,
    parameter int TRIG_W  = 3,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] mode_pulse_i,
    input  logic [NUM_SRC-1:0] sw_set_i,
    input  logic [NUM_SRC-1:0] sw_clr_i,
    input  logic               trig_vld_i,
    input  logic [TRIG_W-1:0]  trig_idx_i,
    input  logic               enter_vld_i,
    input  logic [IDX_W-1:0]   enter_idx_i,
    input  logic               ret_vld_i,
    input  logic [IDX_W-1:0]   ret_idx_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] act_o,
    output logic               top_vld_o,
    output logic [IDX_W-1:0]   top_idx_o
);

    logic [NUM_SRC-1:0] line_s;
    logic [NUM_SRC-1:0] rise_s;
    logic [NUM_SRC-1:0] trig_hit;
    logic [NUM_SRC-1:0] enter_hit;
    logic [NUM_SRC-1:0] ret_hit;
    logic [NUM_SRC-1:0] cand;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign trig_hit[i]  = trig_vld_i  && (32'(trig_idx_i)  == i);
        assign enter_hit[i] = enter_vld_i && (32'(enter_idx_i) == i);
        assign ret_hit[i]   = ret_vld_i   && (32'(ret_idx_i)   == i);

        irq_req_sampler i_samp (
            .clk    (clk),
            .rst_n  (rst_n),
            .req_i  (req_i[i]),
            .line_o (line_s[i]),
            .rise_o (rise_s[i])
        );

        irq_src_cell i_cell (
            .clk          (clk),
            .rst_n        (rst_n),
            .line_i       (line_s[i]),
            .rise_i       (rise_s[i]),
            .pulse_mode_i (mode_pulse_i[i]),
            .sw_set_i     (sw_set_i[i]),
            .sw_clr_i     (sw_clr_i[i]),
            .trig_hit_i   (trig_hit[i]),
            .enter_hit_i  (enter_hit[i]),
            .ret_hit_i    (ret_hit[i]),
            .pend_o       (pend_o[i]),
            .act_o        (act_o[i])
        );
    end

    assign cand = pend_o & ~act_o;

    irq_prio_pick #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) i_pick (
        .cand_i (cand),
        .vld_o  (top_vld_o),
        .idx_o  (top_idx_o)
    );

    AST_PICK_IS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
        top_vld_o |-> (pend_o[top_idx_o] && !act_o[top_idx_o])) else $error("bad pick"); // R10
    AST_PICK_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend_o & ~act_o)) == top_vld_o) else $error("valid mismatch"); // R10
    AST_TRIG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_vld_i && 32'(trig_idx_i) >= NUM_SRC && sw_set_i == '0 && !ret_vld_i
         && (req_i == '0) && (line_s == '0)) |=> ($countones(pend_o) <= $countones($past(pend_o)))) else $error("trigger out of range acted"); // R4

endmodule

// File: tb/test_irq_state_tracker.sv
module test_irq_state_tracker;

    localparam int N  = 6;
    localparam int TW = 3;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic [N-1:0]  mode = 6'b111000;
    logic [N-1:0]  sset = '0;
    logic [N-1:0]  sclr = '0;
    logic          tvld = 1'b0;
    logic [TW-1:0] tidx = '0;
    logic          evld = 1'b0;
    logic [IW-1:0] eidx = '0;
    logic          rvld = 1'b0;
    logic [IW-1:0] ridx = '0;
    logic [N-1:0]  pend;
    logic [N-1:0]  act;
    logic          tv;
    logic [IW-1:0] ti;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_state_tracker #(.NUM_SRC(N), .TRIG_W(TW), .IDX_W(IW)) i_irq_state_tracker (
        .clk(clk), .rst_n(rst_n), .req_i(req), .mode_pulse_i(mode),
        .sw_set_i(sset), .sw_clr_i(sclr), .trig_vld_i(tvld), .trig_idx_i(tidx),
        .enter_vld_i(evld), .enter_idx_i(eidx), .ret_vld_i(rvld), .ret_idx_i(ridx),
        .pend_o(pend), .act_o(act), .top_vld_o(tv), .top_idx_o(ti)
    );

    // bits [9:4] set pattern, [3] expected valid, [2:0] expected index
    localparam logic [9:0] VEC [8] = '{
        {6'b000001, 1'b1, 3'd0},
        {6'b101000, 1'b1, 3'd3},
        {6'b110000, 1'b1, 3'd4},
        {6'b000000, 1'b0, 3'd0},
        {6'b100000, 1'b1, 3'd5},
        {6'b000110, 1'b1, 3'd1},
        {6'b111111, 1'b1, 3'd0},
        {6'b010100, 1'b1, 3'd2}
    };

    task automatic check(input string tag, input logic [31:0] actual, input logic [31:0] expct);
        total++;
        if (actual !== expct) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, actual, expct);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe_set(input logic [N-1:0] v);
        sset = v; cyc(1); sset = '0;
    endtask

    task automatic strobe_clr(input logic [N-1:0] v);
        sclr = v; cyc(1); sclr = '0;
    endtask

    task automatic enter(input int s);
        evld = 1'b1; eidx = IW'(s); cyc(1); evld = 1'b0;
    endtask

    task automatic leave(input int s);
        rvld = 1'b1; ridx = IW'(s); cyc(1); rvld = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cyc(2);
        check("R1 pend", pend, 0);
        check("R1 act", act, 0);
        check("R1 vld", tv, 0);
        rst_n = 1'b1;
        cyc(1);

        // R10 table walk
        for (int v = 0; v < 8; v++) begin
            strobe_clr('1);
            strobe_set(VEC[v][9:4]);
            check("R10 vld", tv, VEC[v][3]);
            if (VEC[v][3]) check("R10 idx", ti, VEC[v][2:0]);
        end

        // R4 trigger by index, out of range ignored
        strobe_clr('1);
        tvld = 1'b1; tidx = 3'd4; cyc(1); tvld = 1'b0;
        check("R4 trig in range", pend, 6'b010000);
        tvld = 1'b1; tidx = 3'd6; cyc(1);
        tidx = 3'd7; cyc(1); tvld = 1'b0;
        check("R4 trig out of range", pend, 6'b010000);

        // R6 set wins over clear, R5 clear alone
        sset = 6'b010000; sclr = 6'b010000; cyc(1); sset = '0; sclr = '0;
        check("R6 set beats clr", pend[4], 1);
        cyc(2);
        check("R5 pending persists", pend[4], 1);
        strobe_clr(6'b010000);
        check("R5 clr", pend[4], 0);

        // R2 level line, two edges of latency
        req[1] = 1'b1; cyc(1);
        check("R2 not yet", pend[1], 0);
        cyc(1);
        check("R2 level pending", pend[1], 1);
        strobe_clr(6'b000010);
        check("R6 hw beats clr", pend[1], 1);

        // R7 entry of level with line high: active-and-pending
        enter(1);
        check("R7 level act", act[1], 1);
        check("R7 level still pend", pend[1], 1);
        check("R10 active excluded", tv, 0);

        // R8 return with line low
        req[1] = 1'b0; cyc(1);
        leave(1);
        check("R8 low act", act[1], 0);
        check("R8 low pend", pend[1], 0);

        // R8 return with line high
        req[1] = 1'b1; cyc(2);
        enter(1);
        leave(1);
        check("R8 high act", act[1], 0);
        check("R8 high repend", pend[1], 1);
        check("R10 repend pick", ti, 1);
        req[1] = 1'b0; cyc(2);
        strobe_clr('1);
        check("R8 cleanup", pend, 0);

        // R3 pulse source: single event on held line
        req[3] = 1'b1; cyc(2);
        check("R3 edge pend", pend[3], 1);
        strobe_clr(6'b001000);
        cyc(3);
        check("R3 held no repend", pend[3], 0);
        req[3] = 1'b0; cyc(2);

        // R9 pulse return without new pulse
        strobe_set(6'b001000);
        enter(3);
        check("R7 pulse entry act", act[3], 1);
        check("R7 pulse entry pend", pend[3], 0);
        leave(3);
        check("R9 quiet act", act[3], 0);
        check("R9 quiet pend", pend[3], 0);

        // R9 pulse during handler
        strobe_set(6'b001000);
        enter(3);
        req[3] = 1'b1; cyc(1); req[3] = 1'b0; cyc(1);
        check("R9 act+pend act", act[3], 1);
        check("R9 act+pend pend", pend[3], 1);
        leave(3);
        check("R9 latched act", act[3], 0);
        check("R9 latched pend", pend[3], 1);

        // R7 entry on non-pending ignored
        strobe_clr('1);
        enter(2);
        check("R7 idle entry", act, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule